// File: doc/BRIEF.md
# Multi-Length PRBS Pattern Generator

This block produces a pseudo-random NRZ bit stream for diagnostics and signal tracing in a switching fabric. It emits one bit per rising clock edge. The stream comes from a linear feedback shift register (LFSR) that can run as any of four maximal-length sequences. Software picks the sequence at run time through a field in a single configuration register. The same register holds an enable bit and an output-complement bit.

The register is reached through a plain port: address, write data, write strobe and combinational read data. A small controller moves the LFSR through three states:

- **IDLE**: the generator is off. `ser_valid` is low and `ser_out` rests at the invert level.
- **SEED**: one cycle in which the LFSR is loaded with all ones at the selected length. That length is then latched as the running length.
- **RUN**: the LFSR steps once per cycle and `ser_valid` is high.

The controller moves between these states as follows:

- **IDLE→SEED** when the enable bit is 1.
- **SEED→RUN** when the enable bit is still 1.
- **SEED→IDLE** when the enable bit is 0.
- **RUN→IDLE** when the enable bit is cleared.
- **RUN→SEED** when the length field differs from the latched running length.
- **RUN→RUN** otherwise.

Top module: `prbs_pattern_gen`

## Requirements
- R1: The configuration register is at address 0x284. Its bit 4 is the enable, bits [3:2] are the length select and bit 1 is the invert. Reads at 0x284 return these three fields as written and return 0 in bits 7, 6, 5 and 0. Reads at any other address return 0.
- R2: A write to any address other than 0x284 changes neither the register contents nor the running bit stream.
- R3: After a write that sets the enable bit from IDLE, `ser_valid` is low on the next cycle and high on the cycle after. The first bit in the valid stream is 1, because the seed is all ones.
- R4: The length codes select these feedback polynomials: 00 gives x^7+x^6+1, 01 gives x^9+x^5+1, 10 gives x^10+x^7+1 and 11 gives x^11+x^9+1. For a length of N, bit k+1 of the stream equals bit k+1-N XOR bit k+1-T, where T is the second tap.
- R5: Each sequence repeats with a period of 2^N-1 bits and contains exactly 2^(N-1) ones per period.
- R6: Changing only the invert bit while running complements `ser_out` from the next cycle on. It does not reseed the LFSR and does not drop `ser_valid`.
- R7: Changing the length field while running drops `ser_valid` for exactly one cycle. The LFSR then restarts from the all-ones seed at the new length.
- R8: Clearing the enable bit drops `ser_valid` on the next clock. While disabled, `ser_out` equals the invert bit.
- R9: After reset the register reads 0, `ser_valid` is 0 and `ser_out` is 0.
- R10: While running, the active LFSR bits are never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the output changes after each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| ser_out | output | 1 | Serial NRZ pattern bit |
| ser_valid | output | 1 | High while the pattern is running |

## Verification
All eight combinations of length code and invert bit are swept. Each combination runs for a full period plus a margin. Every bit is compared against an arithmetic LFSR model, and the ones per period are counted. This separates a wrong tap, a wrong length, a wrong seed and a missing complement. Further runs perform register writes in the middle of a stream: a write to a foreign address, a change of invert only, a change of length only, and a disable. Together they tell apart an ignored write, an update in place and a reseed. Register writes with the unused bits set show whether those bits are masked out on readback.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEED = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_e;

    localparam int LFSR_W   = 11;
    localparam int NUM_LENS = 4;

    // register length for a length-select code
    function automatic int len_bits(input logic [1:0] code);
        case (code)
            2'd0:    len_bits = 7;
            2'd1:    len_bits = 9;
            2'd2:    len_bits = 10;
            default: len_bits = 11;
        endcase
    endfunction

    // second feedback tap for a length-select code
    function automatic int tap_bits(input logic [1:0] code);
        case (code)
            2'd0:    tap_bits = 6;
            2'd1:    tap_bits = 5;
            2'd2:    tap_bits = 7;
            default: tap_bits = 9;
        endcase
    endfunction

endpackage

// File: rtl/prbs_cfg_regs.sv
module prbs_cfg_regs #(
    parameter int              ADDR_W   = 12,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h284
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cfg_en,
    output logic [1:0]        cfg_len,
    output logic              cfg_inv
);
    localparam logic [DATA_W-1:0] CFG_MASK = DATA_W'(8'h1E);

    logic [DATA_W-1:0] cfg_q;
    logic              hit;

    assign hit = (reg_addr == CFG_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (reg_we && hit) begin
            cfg_q <= reg_wdata & CFG_MASK;
        end
    end

    assign reg_rdata = hit ? cfg_q : '0;
    assign cfg_en    = cfg_q[4];
    assign cfg_len   = cfg_q[3:2];
    assign cfg_inv   = cfg_q[1];

    // R1
    cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit) |=> (cfg_q == ($past(reg_wdata) & CFG_MASK)));

    // R2
    foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_we && hit)) |=> $stable(cfg_q));

endmodule

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
    import prbs_gen_pkg::*;
#(
    parameter int W = LFSR_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       step,
    input  logic [1:0] len_sel,
    output logic       out_bit
);
    logic [W-1:0]        state_q;
    logic [NUM_LENS-1:0] fb_vec;
    logic [NUM_LENS-1:0] msb_vec;
    logic [W-1:0]        mask_vec [NUM_LENS];

    genvar g;
    generate
        for (g = 0; g < NUM_LENS; g++) begin : g_len
            localparam int N = len_bits(2'(g));
            localparam int T = tap_bits(2'(g));
            assign fb_vec[g]   = state_q[N-1] ^ state_q[T-1];
            assign msb_vec[g]  = state_q[N-1];
            assign mask_vec[g] = W'((1 << N) - 1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= mask_vec[len_sel];
        end else if (step) begin
            state_q <= {state_q[W-2:0], fb_vec[len_sel]} & mask_vec[len_sel];
        end
    end

    assign out_bit = msb_vec[len_sel];

    // R10
    lfsr_no_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ((state_q & mask_vec[len_sel]) != '0));

endmodule

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
    import prbs_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_en,
    input  logic [1:0] cfg_len,
    output logic       lfsr_load,
    output logic       lfsr_step,
    output logic [1:0] lfsr_sel,
    output logic       run_valid
);
    gen_state_e state_q, state_d;
    logic [1:0] run_len_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cfg_en) state_d = ST_SEED;
            ST_SEED: state_d = cfg_en ? ST_RUN : ST_IDLE;
            ST_RUN: begin
                if (!cfg_en)                    state_d = ST_IDLE;
                else if (cfg_len != run_len_q)  state_d = ST_SEED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            run_len_q <= 2'd0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SEED) run_len_q <= cfg_len;
        end
    end

    always_comb begin
        lfsr_load = (state_q == ST_SEED);
        lfsr_step = (state_q == ST_RUN);
        run_valid = (state_q == ST_RUN);
        lfsr_sel  = (state_q == ST_SEED) ? cfg_len : run_len_q;
    end

    // R3
    seed_then_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_load && cfg_en) |=> run_valid);

    // R7
    len_change_reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && cfg_en && (cfg_len != lfsr_sel)) |=> (lfsr_load && !run_valid));

    // R8
    disable_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !run_valid);

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
    import prbs_gen_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h284
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ser_out,
    output logic              ser_valid
);
    logic       cfg_en, cfg_inv;
    logic [1:0] cfg_len;
    logic       lfsr_load, lfsr_step, lfsr_bit, run_valid;
    logic [1:0] lfsr_sel;

    prbs_cfg_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CFG_ADDR (CFG_ADDR)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .cfg_en    (cfg_en),
        .cfg_len   (cfg_len),
        .cfg_inv   (cfg_inv)
    );

    prbs_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_len   (cfg_len),
        .lfsr_load (lfsr_load),
        .lfsr_step (lfsr_step),
        .lfsr_sel  (lfsr_sel),
        .run_valid (run_valid)
    );

    prbs_lfsr #(.W(LFSR_W)) lfsr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (lfsr_load),
        .step    (lfsr_step),
        .len_sel (lfsr_sel),
        .out_bit (lfsr_bit)
    );

    assign ser_valid = run_valid;
    assign ser_out   = run_valid ? (lfsr_bit ^ cfg_inv) : cfg_inv;

endmodule

// File: tb/prbs_pattern_gen_tb.sv
module prbs_pattern_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic        ser_out, ser_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of the sequence
    int unsigned m_state;
    int          m_len;
    bit          m_inv;
    int          seq_err;
    int          ones;

    always #2.5 clk = ~clk;

    prbs_pattern_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .ser_out   (ser_out),
        .ser_valid (ser_valid)
    );

    function automatic int nbits(input int code);
        case (code)
            0: return 7;
            1: return 9;
            2: return 10;
            default: return 11;
        endcase
    endfunction

    function automatic int tbits(input int code);
        case (code)
            0: return 6;
            1: return 5;
            2: return 7;
            default: return 9;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic seed_model(input int code, input bit inv);
        m_len   = code;
        m_inv   = inv;
        m_state = (1 << nbits(code)) - 1;
        seq_err = 0;
        ones    = 0;
    endtask

    // compare one bit at this negedge, advance the model, move to next negedge
    task automatic tick();
        int n, t;
        bit b, fb;
        n  = nbits(m_len);
        t  = tbits(m_len);
        b  = m_state[n-1];
        if (ser_valid !== 1'b1 || ser_out !== (b ^ m_inv)) seq_err++;
        ones += int'(b);
        fb = m_state[n-1] ^ m_state[t-1];
        m_state = ((m_state << 1) | int'(fb)) & ((1 << n) - 1);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        reg_addr  = 12'h284;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input int exp);
        reg_addr = a;
        #1;
        chk(req, int'(reg_rdata), exp);
        reg_addr = 12'h284;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk("R9 valid", int'(ser_valid), 0);
        chk("R9 out", int'(ser_out), 0);
        rd_chk("R9 rdata", 12'h284, 0);

        // R1 unused bits masked, no enable
        wr(12'h284, 8'hE1);
        rd_chk("R1 mask", 12'h284, 0);
        repeat (3) @(negedge clk);
        chk("R1 no enable", int'(ser_valid), 0);
        wr(12'h284, 8'hFF);
        rd_chk("R1 readback", 12'h284, 'h1E);
        rd_chk("R1 other addr", 12'h280, 0);
        wr(12'h284, 8'h00);
        repeat (2) @(negedge clk);

        // R4 R5 R3 R8 sweep over length and invert
        for (int code = 0; code < 4; code++) begin
            for (int inv = 0; inv < 2; inv++) begin
                int per;
                per = (1 << nbits(code)) - 1;
                wr(12'h284, 8'(16 | (code << 2) | (inv << 1)));
                @(negedge clk);
                chk("R3 seed cycle", int'(ser_valid), 0);
                @(negedge clk);
                chk("R3 first bit", int'(ser_out), 1 ^ inv);
                seed_model(code, 1'(inv));
                for (int i = 0; i < per; i++) tick();
                chk("R5 ones per period", ones, 1 << (nbits(code) - 1));
                for (int i = 0; i < 16; i++) tick();
                chk("R4 R5 sequence", seq_err, 0);
                wr(12'h284, 8'(inv << 1));
                @(negedge clk);
                chk("R8 valid", int'(ser_valid), 0);
                chk("R8 level", int'(ser_out), inv);
            end
        end

        // R2 foreign write while running
        wr(12'h284, 8'h14);
        @(negedge clk);
        @(negedge clk);
        seed_model(1, 0);
        for (int i = 0; i < 20; i++) tick();
        reg_addr = 12'h285; reg_wdata = 8'h00; reg_we = 1'b1;
        tick();
        reg_we = 1'b0; reg_addr = 12'h284;
        for (int i = 0; i < 20; i++) tick();
        chk("R2 stream", seq_err, 0);
        rd_chk("R2 reg", 12'h284, 'h14);

        // R6 invert change in place
        reg_wdata = 8'h16; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
        m_inv = 1;
        for (int i = 0; i < 30; i++) tick();
        chk("R6 invert in place", seq_err, 0);

        // R7 length change reseeds
        reg_wdata = 8'h18; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
        @(negedge clk);
        chk("R7 valid gap", int'(ser_valid), 0);
        @(negedge clk);
        seed_model(2, 0);
        for (int i = 0; i < 1023; i++) tick();
        chk("R7 ones", ones, 512);
        for (int i = 0; i < 8; i++) tick();
        chk("R7 new sequence", seq_err, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule